// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block connects a simple single-word request bus inside a synchronous design to an external asynchronous static RAM of 32K words by 16 bits. The RAM has active-low controls for chip select, write strobe and output drive, plus one active-low enable for each byte lane. The controller accepts one read or write at a time. It works through a fixed sequence of SETUP, ACCESS and RECOVER phases, each lasting a set number of clocks. During that sequence it holds the address, the lane enables and any write data steady.

The ACCESS length comes from the memory's access-time grade in nanoseconds and the controller clock period, rounded up to whole cycles. SETUP and RECOVER lengths are separate parameters. The memory stores write data when its write strobe rises, at the start of RECOVER. The controller keeps driving the data pins through that edge. It turns on its data drivers only in write phases, and never while the memory could be driving the pins.

A read captures the pins on the last ACCESS clock and returns the word with a one-cycle valid pulse. Lanes the request did not select come back as zero. A request whose byte mask is empty runs through the same phases, but it never strobes the memory.

Top module: `asram_port_ctrl`

## Requirements
- R1: After reset, req_ready is 1, busy is 0, sram_ce_n, sram_we_n and sram_oe_n are 1, sram_be_n is 2'b11, sram_dq_oe is 0 and rd_valid is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. From the next cycle, req_ready is 0 and busy is 1 for exactly SETUP_CYC + ACCESS_CYC + RECOVER_CYC cycles. ACCESS_CYC is ceil(T_AA_NS / CLK_PERIOD_NS).
- R3: For a whole transaction, sram_ce_n is 0 and sram_addr holds the request address. sram_be_n is the inverted byte mask: mask bit 0 selects data bits 7:0 and mask bit 1 selects bits 15:8.
- R4: In a read with a non-empty mask, sram_oe_n is 0 exactly during the ACCESS cycles, and sram_we_n stays 1 throughout.
- R5: In a write with a non-empty mask, sram_we_n is 0 exactly during the ACCESS cycles, and sram_oe_n stays 1. When sram_we_n rises, sram_dq_oe is still 1 and the address and data are unchanged, so only the selected lanes of memory change.
- R6: sram_dq_oe is 1 only during ACCESS and RECOVER of a write with a non-empty mask. It is never 1 while sram_oe_n is 0. It rises only after a cycle in which sram_oe_n was 1.
- R7: For a read, rd_valid is 1 for exactly one cycle, the first RECOVER cycle. rd_data then holds the memory word sampled on the last ACCESS clock, with unselected lanes forced to zero.
- R8: For a request with mask 2'b00, sram_we_n, sram_oe_n and sram_dq_oe stay inactive and memory is unchanged. A read still pulses rd_valid and returns 16'h0000.
- R9: If req_valid is raised while busy is 1 and dropped before the controller is idle again, the request is ignored.
- R10: Whenever the controller is idle, sram_ce_n is 1 and sram_be_n is 2'b11 (standby).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte select; bit 0 for bits 7:0, bit 1 for bits 15:8 |
| req_ready | output | 1 | Controller idle; a request is taken this cycle |
| busy | output | 1 | A transaction is in progress |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | One-cycle pulse when rd_data is fresh |
| sram_addr | output | 15 | Memory address pins |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_oe_n | output | 1 | Memory output drive, active low |
| sram_be_n | output | 2 | Memory lane enables, active low |
| sram_dq_out | output | 16 | Data the controller drives onto the pins |
| sram_dq_oe | output | 1 | Controller drive enable for the data pins |
| sram_dq_in | input | 16 | Data seen on the pins |

## Verification
The assertions check the bus-turnaround rules on every cycle: no controller drive while the memory's outputs are on, and drive only after a cycle with output drive off. They also check that the write strobe and output drive are never both active, that idle means standby, that address and data are steady across the rising write strobe, and that the read-valid pulse lasts one cycle. Only the bench scenarios can show that the phase lengths are right and that selected lanes actually reach memory while unselected lanes are left alone. The same goes for read-back of earlier writes, zero lanes on partial reads, the empty-mask case and requests dropped while busy. The bench checks these with a pin-level memory model and a shadow copy of memory contents.

// File: rtl/asram_pkg.sv
// Shared types for the asynchronous SRAM port controller.
// Assumes: exactly one transaction is in flight at a time.
package asram_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETUP   = 2'd1,
        PH_ACCESS  = 2'd2,
        PH_RECOVER = 2'd3
    } phase_t;
endpackage

// File: rtl/asram_phase_seq.sv
// Phase sequencer: moves through IDLE, SETUP, ACCESS and RECOVER, holding each
// non-idle phase for its parameter number of clocks.
// Assumes: every phase length is at least one cycle; start is seen only in IDLE.
module asram_phase_seq
    import asram_pkg::*;
#(
    parameter int SETUP_CYC   = 1,
    parameter int ACCESS_CYC  = 2,
    parameter int RECOVER_CYC = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_t phase,
    output logic   last
);
    localparam int MAX_A  = (SETUP_CYC > ACCESS_CYC) ? SETUP_CYC : ACCESS_CYC;
    localparam int MAX_C  = (MAX_A > RECOVER_CYC) ? MAX_A : RECOVER_CYC;
    localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);
    localparam logic [CNT_W-1:0] LD_SETUP   = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ACCESS  = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RECOVER = CNT_W'(RECOVER_CYC - 1);

    logic [CNT_W-1:0] remain;

    // Phase ends when the remaining-cycle count reaches zero.
    assign last = (remain == '0);

    // Phase register and per-phase down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            remain <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_SETUP;
                        remain <= LD_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        phase  <= PH_ACCESS;
                        remain <= LD_ACCESS;
                    end else begin
                        remain <= remain - CNT_W'(1);
                    end
                end
                PH_ACCESS: begin
                    if (last) begin
                        phase  <= PH_RECOVER;
                        remain <= LD_RECOVER;
                    end else begin
                        remain <= remain - CNT_W'(1);
                    end
                end
                PH_RECOVER: begin
                    if (last) begin
                        phase  <= PH_IDLE;
                        remain <= '0;
                    end else begin
                        remain <= remain - CNT_W'(1);
                    end
                end
                default: begin
                    phase  <= PH_IDLE;
                    remain <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/asram_pin_drive.sv
// Pin decoder: turns the current phase and the latched request into memory
// control levels, address, lane enables and data-bus drive.
// Assumes: the phase and the request fields come straight from flops, so the
// pins change only just after a clock edge.
module asram_pin_drive
    import asram_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  phase_t              phase,
    input  logic                wr,
    input  logic [LANES-1:0]    mask,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [ADDR_W-1:0]   pin_addr,
    output logic                pin_ce_n,
    output logic                pin_we_n,
    output logic                pin_oe_n,
    output logic [LANES-1:0]    pin_be_n,
    output logic [DATA_W-1:0]   pin_dq_out,
    output logic                pin_dq_oe
);
    logic active;
    logic any_lane;
    logic in_access;
    logic in_tail;

    // Phase flags used by all pin equations.
    always_comb begin
        active    = (phase != PH_IDLE);
        any_lane  = |mask;
        in_access = (phase == PH_ACCESS);
        in_tail   = (phase == PH_ACCESS) || (phase == PH_RECOVER);
    end

    // Control and lane pins: standby in idle, strobe only in ACCESS.
    always_comb begin
        pin_addr   = addr;
        pin_ce_n   = !active;
        pin_be_n   = active ? ~mask : '1;
        pin_we_n   = !(in_access && wr && any_lane);
        pin_oe_n   = !(in_access && !wr && any_lane);
        pin_dq_oe  = in_tail && wr && any_lane;
        pin_dq_out = wdata;
    end
endmodule

// File: rtl/asram_read_capture.sv
// Read capture: samples the data pins on the last ACCESS clock of a read,
// zeroes the lanes that were not selected, and pulses a valid flag.
// Assumes: the memory output has settled within the ACCESS window.
module asram_read_capture
    import asram_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic              last,
    input  logic              wr,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] pin_dq,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] keep;
    logic              take;

    // One keep-mask slice per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign keep[g*LANE_W +: LANE_W] = {LANE_W{mask[g]}};
    end

    // Sample point: last cycle of ACCESS in a read.
    assign take = (phase == PH_ACCESS) && last && !wr;

    // Capture register and one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= take;
            if (take) begin
                rd_data <= pin_dq & keep;
            end
        end
    end
endmodule

// File: rtl/asram_port_ctrl.sv
// Top of the asynchronous SRAM port controller. Takes one request at a time
// from the internal bus, latches it, and runs the phase sequence that drives
// the memory pins.
// Assumes: the data pins are resolved outside this block from sram_dq_out and
// sram_dq_oe, and the memory's read data comes back on sram_dq_in.
module asram_port_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 16,
    parameter int LANES         = 2,
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_AA_NS       = 10,
    parameter int SETUP_CYC     = 1,
    parameter int RECOVER_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_ready,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [LANES-1:0]  sram_be_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int ACCESS_CYC = (T_AA_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

    phase_t            phase;
    logic              last;
    logic              accept;
    logic              lat_wr;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic [LANES-1:0]  lat_mask;

    // Handshake: a request is taken whenever the sequencer sits in IDLE.
    assign req_ready = (phase == PH_IDLE);
    assign busy      = !req_ready;
    assign accept    = req_valid && req_ready;

    // Request latch: holds the fields steady for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_wr    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_mask  <= '0;
        end else if (accept) begin
            lat_wr    <= req_write;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_mask  <= req_mask;
        end
    end

    asram_phase_seq #(
        .SETUP_CYC  (SETUP_CYC),
        .ACCESS_CYC (ACCESS_CYC),
        .RECOVER_CYC(RECOVER_CYC)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(accept),
        .phase(phase),
        .last (last)
    );

    asram_pin_drive #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .LANES (LANES)
    ) u_pins (
        .phase     (phase),
        .wr        (lat_wr),
        .mask      (lat_mask),
        .addr      (lat_addr),
        .wdata     (lat_wdata),
        .pin_addr  (sram_addr),
        .pin_ce_n  (sram_ce_n),
        .pin_we_n  (sram_we_n),
        .pin_oe_n  (sram_oe_n),
        .pin_be_n  (sram_be_n),
        .pin_dq_out(sram_dq_out),
        .pin_dq_oe (sram_dq_oe)
    );

    asram_read_capture #(
        .DATA_W(DATA_W),
        .LANES (LANES)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .last    (last),
        .wr      (lat_wr),
        .mask    (lat_mask),
        .pin_dq  (sram_dq_in),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );
endmodule

// File: rtl/asram_port_ctrl_chk.sv
// Protocol checker for the asynchronous SRAM port controller, bound to the top.
// Watches only the top-level ports.
module asram_port_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              busy,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic [LANES-1:0]  sram_be_n,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe
);
    // R6: controller never drives while memory output drive is on.
    p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    // R6: drive turns on only after a cycle with output drive off.
    p_drive_after_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> $past(sram_oe_n));

    // R4: write strobe and output drive are never active together.
    p_strobe_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    // R10: idle means standby on every control pin.
    p_idle_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe
                       && sram_be_n == '1));

    // R5: the rising write strobe sees selected chip, held address and data.
    p_we_rise_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_ce_n && sram_dq_oe && $stable(sram_addr)
                              && $stable(sram_dq_out)));

    // R3: address stays put while the chip is selected.
    p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    // R7: read valid is a single-cycle pulse.
    p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R8: with no lane selected, no strobe and no drive.
    p_empty_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_be_n == '1) |-> (sram_we_n && sram_oe_n && !sram_dq_oe));

    // R2: busy is always the complement of ready.
    p_busy_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy != req_ready);
endmodule

bind asram_port_ctrl asram_port_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_be_n  (sram_be_n),
    .sram_dq_out(sram_dq_out),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/asram_port_ctrl_test.sv
// Bench: behavioural cycle model of the controller plus a pin-level memory
// model, compared at every falling clock edge.
module asram_port_ctrl_test;
    localparam int CLK_NS = 8;
    localparam int S_CYC  = 1;
    localparam int A_CYC  = (10 + CLK_NS - 1) / CLK_NS;
    localparam int R_CYC  = 1;
    localparam int TOT    = S_CYC + A_CYC + R_CYC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, busy, rd_valid;
    logic [15:0] rd_data;
    logic [14:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [1:0]  sram_be_n;
    logic [15:0] sram_dq_out;
    logic [15:0] sram_dq_in = 16'hA5A5;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    bit          m_act = 0;
    int          m_k = 0;
    bit          m_wr = 0;
    logic [14:0] m_addr = '0;
    logic [15:0] m_wdata = '0;
    logic [1:0]  m_mask = '0;
    logic [15:0] m_exp_rd = '0;
    bit          m_taken = 0;
    logic        prev_we_n = 1'b1;

    logic [15:0] mem [int];
    logic [15:0] shadow [int];

    asram_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [15:0] seed_word(input int a);
        return 16'(a * 7 + 16'h3C21);
    endfunction

    function automatic logic [15:0] mem_get(input int a);
        return mem.exists(a) ? mem[a] : seed_word(a);
    endfunction

    function automatic logic [15:0] shadow_get(input int a);
        return shadow.exists(a) ? shadow[a] : seed_word(a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int actual, input int expected);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
        end
    endtask

    // One clock: advance model, compare pins, run memory model.
    task automatic step();
        bit          e_acc, e_tail, e_any;
        logic [15:0] w, nw;
        @(negedge clk);
        m_taken = 0;
        if (!rst_n) begin
            m_act = 0;
        end else if (!m_act) begin
            if (req_valid) begin
                m_act = 1; m_k = 0; m_taken = 1;
                m_wr = req_write; m_addr = req_addr;
                m_wdata = req_wdata; m_mask = req_mask;
                w = shadow_get(int'(req_addr));
                m_exp_rd = {m_mask[1] ? w[15:8] : 8'h00, m_mask[0] ? w[7:0] : 8'h00};
                if (req_write) begin
                    nw = w;
                    if (req_mask[0]) nw[7:0] = req_wdata[7:0];
                    if (req_mask[1]) nw[15:8] = req_wdata[15:8];
                    shadow[int'(req_addr)] = nw;
                end
            end
        end else begin
            m_k++;
            if (m_k == TOT) m_act = 0;
        end
        if (rst_n) begin
            e_acc  = m_act && m_k >= S_CYC && m_k < S_CYC + A_CYC;
            e_tail = m_act && m_k >= S_CYC;
            e_any  = (m_mask != 2'b00);
            chk(req_ready == !m_act, "R2", "req_ready", int'(req_ready), int'(!m_act));
            chk(busy == m_act, "R2", "busy", int'(busy), int'(m_act));
            chk(sram_ce_n == !m_act, "R10", "sram_ce_n", int'(sram_ce_n), int'(!m_act));
            chk(sram_be_n == (m_act ? ~m_mask : 2'b11), "R3", "sram_be_n",
                int'(sram_be_n), int'(m_act ? ~m_mask : 2'b11));
            if (m_act)
                chk(sram_addr == m_addr, "R3", "sram_addr", int'(sram_addr), int'(m_addr));
            chk(sram_oe_n == !(e_acc && !m_wr && e_any), "R4", "sram_oe_n",
                int'(sram_oe_n), int'(!(e_acc && !m_wr && e_any)));
            chk(sram_we_n == !(e_acc && m_wr && e_any), "R5", "sram_we_n",
                int'(sram_we_n), int'(!(e_acc && m_wr && e_any)));
            chk(sram_dq_oe == (e_tail && m_wr && e_any), "R6", "sram_dq_oe",
                int'(sram_dq_oe), int'(e_tail && m_wr && e_any));
            if (sram_dq_oe)
                chk(sram_dq_out == m_wdata, "R5", "sram_dq_out", int'(sram_dq_out), int'(m_wdata));
            chk(rd_valid == (m_act && !m_wr && m_k == S_CYC + A_CYC), "R7", "rd_valid",
                int'(rd_valid), int'(m_act && !m_wr && m_k == S_CYC + A_CYC));
            if (rd_valid)
                chk(rd_data == m_exp_rd, (m_mask == 2'b00) ? "R8" : "R7", "rd_data",
                    int'(rd_data), int'(m_exp_rd));
        end
        // memory model: contention, write on rising strobe, read drive
        if (!sram_ce_n && !sram_oe_n && sram_we_n && sram_be_n != 2'b11)
            chk(!sram_dq_oe, "R6", "bus contention", int'(sram_dq_oe), 0);
        if (!prev_we_n && sram_we_n && !sram_ce_n) begin
            chk(sram_dq_oe, "R5", "drive at strobe rise", int'(sram_dq_oe), 1);
            w = mem_get(int'(sram_addr));
            if (!sram_be_n[0]) w[7:0] = sram_dq_out[7:0];
            if (!sram_be_n[1]) w[15:8] = sram_dq_out[15:8];
            mem[int'(sram_addr)] = w;
        end
        prev_we_n = sram_we_n;
        if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
            w = mem_get(int'(sram_addr));
            sram_dq_in = {sram_be_n[1] ? 8'hA5 : w[15:8], sram_be_n[0] ? 8'hA5 : w[7:0]};
        end else begin
            sram_dq_in = 16'hA5A5;
        end
    endtask

    task automatic do_req(input bit wr, input logic [14:0] a, input logic [15:0] d,
                          input logic [1:0] m);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        do step(); while (!m_taken);
        req_valid = 0;
        req_wdata = ~d;
        while (m_act) step();
    endtask

    // R9: a request raised while busy and dropped before idle is ignored.
    task automatic busy_poke();
        req_valid = 1; req_write = 1; req_addr = 15'h0111; req_wdata = 16'hDEAD; req_mask = 2'b11;
        do step(); while (!m_taken);
        req_addr = 15'h0222; req_wdata = 16'hBEEF;
        step();
        req_valid = 1;
        step();
        req_valid = 0;
        while (m_act) step();
        repeat (2) begin
            step();
            chk(sram_ce_n && req_ready, "R9", "no second transaction", int'(sram_ce_n), 1);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) step();
        rst_n = 1;
        step();
        // R1: reset state
        chk(req_ready && !busy, "R1", "ready/busy", int'({req_ready, busy}), 2);
        chk(sram_ce_n && sram_we_n && sram_oe_n, "R1", "controls",
            int'({sram_ce_n, sram_we_n, sram_oe_n}), 7);
        chk(sram_be_n == 2'b11 && !sram_dq_oe && !rd_valid, "R1", "lanes/drive/valid",
            int'({sram_be_n, sram_dq_oe, rd_valid}), 12);
        // full-word writes and read-back at edge addresses
        do_req(1, 15'h0000, 16'h1357, 2'b11);
        do_req(1, 15'h7FFF, 16'hFACE, 2'b11);
        do_req(0, 15'h0000, 16'h0, 2'b11);
        do_req(0, 15'h7FFF, 16'h0, 2'b11);
        // lane-selective writes (R5), then partial reads (R7)
        do_req(1, 15'h0040, 16'hAB12, 2'b01);
        do_req(1, 15'h0041, 16'hCD34, 2'b10);
        do_req(0, 15'h0040, 16'h0, 2'b11);
        do_req(0, 15'h0041, 16'h0, 2'b11);
        do_req(0, 15'h7FFF, 16'h0, 2'b01);
        do_req(0, 15'h7FFF, 16'h0, 2'b10);
        // empty mask: no write, read gives zero (R8)
        do_req(1, 15'h0000, 16'h9999, 2'b00);
        do_req(0, 15'h0000, 16'h0, 2'b00);
        do_req(0, 15'h0000, 16'h0, 2'b11);
        // write then read straight after: turnaround (R6)
        do_req(1, 15'h1234, 16'h5A5A, 2'b11);
        do_req(0, 15'h1234, 16'h0, 2'b11);
        busy_poke();
        do_req(0, 15'h0222, 16'h0, 2'b11);
        do_req(0, 15'h0111, 16'h0, 2'b11);
        // mixed sweep
        for (int i = 0; i < 60; i++) begin
            do_req(1'($urandom_range(0, 1)), 15'($urandom_range(0, 31)),
                   16'($urandom), 2'($urandom_range(0, 3)));
        end
        repeat (3) step();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule